// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up and Deep-Sleep Sequencer

This block sits on the controller side of a low-power SDRAM. When its start strobe arrives after reset, it drives the command pins through the fixed bring-up order. It holds NOP with the clock enable high for a settling interval and then closes every bank. A programmable number of auto refreshes follows, spaced by the refresh cycle time. Last come the mode register write and the extended mode register write. The extended word carries the self-refresh array coverage and the output drive strength. When the last register write has settled, a ready flag rises.

While ready, a single strobe puts the memory into its deepest sleep state. The sequencer issues the sleep entry on the clock edge where the clock enable falls, and then keeps the device deselected with the clock enable low. A wake strobe raises the clock enable again. Because the array contents are gone after the deep sleep, the whole bring-up runs again from the settling interval onward. All timing intervals are parameters given in clock cycles, derived from the clock frequency. An optional output register stage is chosen by a parameter.

Top module: `lpsd_init_seq`

## Requirements
- R1: After reset and before a start strobe, ready is low, CKE is high and the pins show NOP (CS low; RAS, CAS and WE high). No other command is issued.
- R2: After start, at least WAIT_CYC cycles of NOP with CKE high pass before the first command.
- R3: The first command is precharge-all: CS, RAS and WE low, CAS high, address bit 10 high.
- R4: REF_NUM (at least 8) auto refreshes follow: CS, RAS and CAS low, WE high, CKE high. The first comes at least TRP_CYC cycles after the precharge, and each later one at least TRFC_CYC cycles after the one before.
- R5: Next comes a mode register write: CS, RAS, CAS and WE all low, bank address 0, and the address bus equal to the mode word input. It comes at least TRFC_CYC cycles after the last refresh.
- R6: TMRD_CYC or more cycles later comes the extended register write. It has the same pin levels, bank address 2 (BA1=1, BA0=0), and the address bus carries the coverage code in bits 2:0 and the drive code in bits 6:5, with all other bits 0.
- R7: Ready rises no earlier than TMRD_CYC cycles after the extended write. While ready is high, the pins show NOP.
- R8: An enter strobe while ready produces one cycle with CKE falling, CS and WE low and RAS and CAS high, with ready low. After that, CKE stays low and CS stays high until a wake strobe.
- R9: Start is ignored except before the first bring-up. Enter is ignored when ready is low. Wake is ignored outside deep sleep. An ignored strobe causes no command and no change of CKE or ready.
- R10: A wake strobe in deep sleep raises CKE with NOP for at least WAIT_CYC cycles. The sequence of R3 to R7 then repeats, using the configuration inputs present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin first bring-up |
| dpd_enter_i | input | 1 | Request deep sleep |
| dpd_exit_i | input | 1 | Request wake from deep sleep |
| mode_word_i | input | ADDR_W | Value written to the mode register |
| drive_sel_i | input | 2 | Drive strength code (0 full, 1 half, 2 quarter) |
| pasr_sel_i | input | 3 | Self-refresh coverage code |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| ready_o | output | 1 | Bring-up complete, memory usable |

## Verification
The bring-up is run three times, each with a different mode word, coverage code and drive code. Each run shows whether the register writes take the configuration that is live at that moment. The first run follows reset, and the other two follow a wake from deep sleep, so they also show whether the wake path replays every step. Each observed command is logged with its cycle number, and the spacing between commands is compared against the interval minimums. Strobes are also sent in the wrong state (before start, while ready and during sleep), which separates a correct state gate from one that reacts to every strobe.

// File: rtl/lpsd_pkg.sv
package lpsd_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_PRE_ALL,
      CMD_REF,
      CMD_MRS,
      CMD_EMRS,
      CMD_DPD_IN,
      CMD_SLEEP
   } cmd_e;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_PWR,
      ST_PRE,
      ST_PRE_W,
      ST_REF,
      ST_REF_W,
      ST_MRS,
      ST_MRS_W,
      ST_EMRS,
      ST_EMRS_W,
      ST_RDY,
      ST_DPD_IN,
      ST_DPD
   } st_e;

   function automatic int ns_to_cyc(input int ns, input int mhz);
      int c;
      c = (ns * mhz + 999) / 1000;
      return (c < 2) ? 2 : c;
   endfunction

endpackage

// File: rtl/lpsd_wait_timer.sv
module lpsd_wait_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load_i)        cnt <= val_i;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero_o = (cnt == '0);
endmodule

// File: rtl/lpsd_pin_stage.sv
module lpsd_pin_stage
   import lpsd_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BA_W    = 2,
   parameter int AP_BIT  = 10,
   parameter bit PIN_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd_i,
   input  logic              ready_i,
   input  logic [ADDR_W-1:0] mode_word_i,
   input  logic [1:0]        drive_sel_i,
   input  logic [2:0]        pasr_sel_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ready_o
);
   logic              c_cke, c_cs, c_ras, c_cas, c_we;
   logic [BA_W-1:0]   c_ba;
   logic [ADDR_W-1:0] c_addr;

   always_comb begin
      c_cke  = 1'b1;
      c_cs   = 1'b0;
      c_ras  = 1'b1;
      c_cas  = 1'b1;
      c_we   = 1'b1;
      c_ba   = '0;
      c_addr = '0;
      unique case (cmd_i)
         CMD_PRE_ALL: begin
            c_ras = 1'b0;
            c_we  = 1'b0;
            c_addr[AP_BIT] = 1'b1;
         end
         CMD_REF: begin
            c_ras = 1'b0;
            c_cas = 1'b0;
         end
         CMD_MRS: begin
            c_ras  = 1'b0;
            c_cas  = 1'b0;
            c_we   = 1'b0;
            c_addr = mode_word_i;
         end
         CMD_EMRS: begin
            c_ras = 1'b0;
            c_cas = 1'b0;
            c_we  = 1'b0;
            c_ba  = BA_W'(2);
            c_addr[2:0] = pasr_sel_i;
            c_addr[6:5] = drive_sel_i;
         end
         CMD_DPD_IN: begin
            c_cke = 1'b0;
            c_we  = 1'b0;
         end
         CMD_SLEEP: begin
            c_cke = 1'b0;
            c_cs  = 1'b1;
         end
         default: ;
      endcase
   end

   generate
      if (PIN_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cke_o   <= 1'b1;
               cs_n_o  <= 1'b0;
               ras_n_o <= 1'b1;
               cas_n_o <= 1'b1;
               we_n_o  <= 1'b1;
               ba_o    <= '0;
               addr_o  <= '0;
               ready_o <= 1'b0;
            end else begin
               cke_o   <= c_cke;
               cs_n_o  <= c_cs;
               ras_n_o <= c_ras;
               cas_n_o <= c_cas;
               we_n_o  <= c_we;
               ba_o    <= c_ba;
               addr_o  <= c_addr;
               ready_o <= ready_i;
            end
         end
      end else begin : g_comb
         assign cke_o   = c_cke;
         assign cs_n_o  = c_cs;
         assign ras_n_o = c_ras;
         assign cas_n_o = c_cas;
         assign we_n_o  = c_we;
         assign ba_o    = c_ba;
         assign addr_o  = c_addr;
         assign ready_o = ready_i;
      end
   endgenerate
endmodule

// File: rtl/lpsd_init_seq.sv
module lpsd_init_seq
   import lpsd_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int BA_W     = 2,
   parameter int AP_BIT   = 10,
   parameter int CLK_MHZ  = 100,
   parameter int WAIT_US  = 200,
   parameter int TRP_NS   = 30,
   parameter int TRFC_NS  = 90,
   parameter int TMRD_CYC = 2,
   parameter int REF_NUM  = 8,
   parameter bit PIN_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dpd_enter_i,
   input  logic              dpd_exit_i,
   input  logic [ADDR_W-1:0] mode_word_i,
   input  logic [1:0]        drive_sel_i,
   input  logic [2:0]        pasr_sel_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ready_o
);
   localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
   localparam int TRP_CYC  = ns_to_cyc(TRP_NS, CLK_MHZ);
   localparam int TRFC_CYC = ns_to_cyc(TRFC_NS, CLK_MHZ);
   localparam int M1  = (WAIT_CYC > TRP_CYC) ? WAIT_CYC : TRP_CYC;
   localparam int M2  = (M1 > TRFC_CYC) ? M1 : TRFC_CYC;
   localparam int MAXV = (M2 > TMRD_CYC) ? M2 : TMRD_CYC;
   localparam int TW  = $clog2(MAXV + 1);
   localparam int RW  = $clog2(REF_NUM + 1);
   localparam logic [TW-1:0] WAIT_V = TW'(WAIT_CYC - 1);
   localparam logic [TW-1:0] TRP_V  = TW'(TRP_CYC - 2);
   localparam logic [TW-1:0] TRFC_V = TW'(TRFC_CYC - 2);
   localparam logic [TW-1:0] TMRD_V = TW'(TMRD_CYC - 2);

   if (REF_NUM < 8)                    begin : g_chk_ref  $error("REF_NUM below 8"); end
   if (TMRD_CYC < 2)                   begin : g_chk_mrd  $error("TMRD_CYC below 2"); end
   if (BA_W < 2)                       begin : g_chk_ba   $error("BA_W below 2"); end
   if (ADDR_W <= AP_BIT || ADDR_W < 7) begin : g_chk_addr $error("ADDR_W too narrow"); end
   if (WAIT_CYC < 2)                   begin : g_chk_wait $error("wait too short"); end

   st_e             st, nxt;
   cmd_e            cmd;
   logic            tload, tzero;
   logic [TW-1:0]   tval;
   logic [RW-1:0]   ref_cnt;

   lpsd_wait_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tload), .val_i(tval), .zero_o(tzero)
   );

   always_comb begin
      nxt   = st;
      tload = 1'b0;
      tval  = '0;
      cmd   = CMD_NOP;
      unique case (st)
         ST_OFF:    if (start_i) begin nxt = ST_PWR; tload = 1'b1; tval = WAIT_V; end
         ST_PWR:    if (tzero) nxt = ST_PRE;
         ST_PRE:    begin cmd = CMD_PRE_ALL; tload = 1'b1; tval = TRP_V; nxt = ST_PRE_W; end
         ST_PRE_W:  if (tzero) nxt = ST_REF;
         ST_REF:    begin cmd = CMD_REF; tload = 1'b1; tval = TRFC_V; nxt = ST_REF_W; end
         ST_REF_W:  if (tzero) nxt = (ref_cnt == RW'(REF_NUM)) ? ST_MRS : ST_REF;
         ST_MRS:    begin cmd = CMD_MRS; tload = 1'b1; tval = TMRD_V; nxt = ST_MRS_W; end
         ST_MRS_W:  if (tzero) nxt = ST_EMRS;
         ST_EMRS:   begin cmd = CMD_EMRS; tload = 1'b1; tval = TMRD_V; nxt = ST_EMRS_W; end
         ST_EMRS_W: if (tzero) nxt = ST_RDY;
         ST_RDY:    if (dpd_enter_i) nxt = ST_DPD_IN;
         ST_DPD_IN: begin cmd = CMD_DPD_IN; nxt = ST_DPD; end
         ST_DPD: begin
            cmd = CMD_SLEEP;
            if (dpd_exit_i) begin nxt = ST_PWR; tload = 1'b1; tval = WAIT_V; end
         end
         default:   nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OFF;
         ref_cnt <= '0;
      end else begin
         st <= nxt;
         if (st == ST_PRE)      ref_cnt <= '0;
         else if (st == ST_REF) ref_cnt <= ref_cnt + 1'b1;
      end
   end

   lpsd_pin_stage #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .PIN_REG(PIN_REG)
   ) u_pins (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ready_i(st == ST_RDY),
      .mode_word_i(mode_word_i), .drive_sel_i(drive_sel_i), .pasr_sel_i(pasr_sel_i),
      .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
      .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o)
   );

   // Checks on the pin side, away from the state machine that drives them
   logic pin_nop, pin_pre, pin_ref, pin_mr;
   logic [RW-1:0] chk_refs;
   assign pin_nop = cke_o && !cs_n_o && ras_n_o && cas_n_o && we_n_o;
   assign pin_pre = cke_o && !cs_n_o && !ras_n_o && cas_n_o && !we_n_o;
   assign pin_ref = cke_o && !cs_n_o && !ras_n_o && !cas_n_o && we_n_o;
   assign pin_mr  = cke_o && !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               chk_refs <= '0;
      else if (pin_pre)                         chk_refs <= '0;
      else if (pin_ref && chk_refs != RW'(REF_NUM)) chk_refs <= chk_refs + 1'b1;
   end

   a_r3_pre_ap: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pre |-> addr_o[AP_BIT]);
   a_r4_ref_count: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mr && ba_o == '0) |-> (chk_refs == RW'(REF_NUM)));
   a_r6_mr_gap: assert property (@(posedge clk) disable iff (!rst_n)
      pin_mr |=> pin_nop);
   a_r7_ready_nop: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> pin_nop);
   a_r8_dpd_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (!cs_n_o && ras_n_o && cas_n_o && !we_n_o && !ready_o));
   a_r8_dpd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_o && $past(!cke_o)) |-> cs_n_o);
   a_r10_wake_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> (!ready_o && pin_nop));
endmodule

// File: tb/sim_lpsd_init_seq.sv
module sim_lpsd_init_seq;
   localparam int ADDR_W = 12;
   localparam int WAIT_E = 20000;   // 200 us at 100 MHz
   localparam int TRP_E  = 3;       // 30 ns
   localparam int TRFC_E = 9;       // 90 ns
   localparam int TMRD_E = 2;
   localparam int NREF   = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, dpd_enter_i = 0, dpd_exit_i = 0;
   logic [ADDR_W-1:0] mode_word_i = '0;
   logic [1:0] drive_sel_i = '0;
   logic [2:0] pasr_sel_i = '0;
   logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o;
   logic [1:0] ba_o;
   logic [ADDR_W-1:0] addr_o;

   always #5 clk = ~clk;

   lpsd_init_seq u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dpd_enter_i(dpd_enter_i),
      .dpd_exit_i(dpd_exit_i), .mode_word_i(mode_word_i), .drive_sel_i(drive_sel_i),
      .pasr_sel_i(pasr_sel_i), .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
      .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o)
   );

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // command log: 1 precharge-all, 2 refresh, 3 register write, 4 sleep entry, 9 other
   int lg_cmd [64];
   int lg_cyc [64];
   int lg_addr[64];
   int lg_ba  [64];
   int lg_n = 0;
   int rdy_cyc = 0;

   always @(negedge clk) begin
      int code;
      code = 0;
      if (cke_o && !cs_n_o) begin
         case ({ras_n_o, cas_n_o, we_n_o})
            3'b111: code = 0;
            3'b010: code = 1;
            3'b001: code = 2;
            3'b000: code = 3;
            default: code = 9;
         endcase
      end else if (!cke_o && !cs_n_o && ras_n_o && cas_n_o && !we_n_o) code = 4;
      else if (!cke_o && cs_n_o) code = 0;
      else if (cke_o && cs_n_o) code = 0;
      else code = 9;
      if (code != 0 && lg_n < 64) begin
         lg_cmd[lg_n] = code; lg_cyc[lg_n] = cyc;
         lg_addr[lg_n] = int'(addr_o); lg_ba[lg_n] = int'(ba_o);
         lg_n = lg_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic wait_ready(output bit ok);
      ok = 0;
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (ready_o) begin ok = 1; rdy_cyc = cyc; break; end
      end
   endtask

   // verifies one full bring-up in the log, begun at cycle t0
   task automatic check_bringup(input string tag, input int t0,
                                input int mw, input int ds, input int ps);
      bit ok;
      wait_ready(ok);
      chk(ok, {tag, " R7 ready reached"}, ok, 1);
      chk(lg_n == NREF + 3, {tag, " R4 command count"}, lg_n, NREF + 3);
      if (lg_n != NREF + 3) return;
      chk(lg_cmd[0] == 1, {tag, " R3 first is precharge-all"}, lg_cmd[0], 1);
      chk(((lg_addr[0] >> 10) & 1) == 1, {tag, " R3 bit 10 high"}, lg_addr[0], 1024);
      chk(lg_cyc[0] - t0 >= WAIT_E, {tag, " R2 settle wait"}, lg_cyc[0] - t0, WAIT_E);
      for (int i = 1; i <= NREF; i++) begin
         chk(lg_cmd[i] == 2, {tag, " R4 refresh code"}, lg_cmd[i], 2);
         chk(lg_cyc[i] - lg_cyc[i-1] >= ((i == 1) ? TRP_E : TRFC_E),
             {tag, " R4 refresh spacing"}, lg_cyc[i] - lg_cyc[i-1], (i == 1) ? TRP_E : TRFC_E);
      end
      chk(lg_cmd[NREF+1] == 3 && lg_ba[NREF+1] == 0, {tag, " R5 mode write bank 0"},
          lg_ba[NREF+1], 0);
      chk(lg_addr[NREF+1] == mw, {tag, " R5 mode word"}, lg_addr[NREF+1], mw);
      chk(lg_cyc[NREF+1] - lg_cyc[NREF] >= TRFC_E, {tag, " R5 spacing"},
          lg_cyc[NREF+1] - lg_cyc[NREF], TRFC_E);
      chk(lg_cmd[NREF+2] == 3 && lg_ba[NREF+2] == 2, {tag, " R6 extended write bank 2"},
          lg_ba[NREF+2], 2);
      chk(lg_addr[NREF+2] == ((ds << 5) | ps), {tag, " R6 extended word"},
          lg_addr[NREF+2], (ds << 5) | ps);
      chk(lg_cyc[NREF+2] - lg_cyc[NREF+1] >= TMRD_E, {tag, " R6 spacing"},
          lg_cyc[NREF+2] - lg_cyc[NREF+1], TMRD_E);
      chk(rdy_cyc - lg_cyc[NREF+2] >= TMRD_E, {tag, " R7 ready delay"},
          rdy_cyc - lg_cyc[NREF+2], TMRD_E);
   endtask

   task automatic t_reset_state();
      chk(ready_o == 0, "R1 ready low", ready_o, 0);
      chk(cke_o == 1, "R1 cke high", cke_o, 1);
      chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R1 NOP pins",
          {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 7);
   endtask

   task automatic t_ignore_before_start();
      lg_n = 0;
      pulse(dpd_enter_i);
      pulse(dpd_exit_i);
      repeat (20) @(negedge clk);
      chk(lg_n == 0, "R9 no command before start", lg_n, 0);
      chk(cke_o == 1 && ready_o == 0, "R9 cke/ready unchanged before start",
          {cke_o, ready_o}, 2);
   endtask

   task automatic t_first_bringup();
      int t0;
      mode_word_i = 12'h032; drive_sel_i = 2'd1; pasr_sel_i = 3'b001;
      lg_n = 0;
      @(negedge clk); start_i = 1'b1; t0 = cyc;
      @(negedge clk); start_i = 1'b0;
      check_bringup("init1", t0, 12'h032, 1, 1);
   endtask

   task automatic t_ignore_while_ready();
      lg_n = 0;
      pulse(start_i);
      pulse(dpd_exit_i);
      repeat (20) @(negedge clk);
      chk(lg_n == 0, "R9 start/wake ignored while ready", lg_n, 0);
      chk(ready_o == 1 && cke_o == 1, "R9 ready kept", {ready_o, cke_o}, 3);
   endtask

   task automatic t_enter_sleep();
      lg_n = 0;
      pulse(dpd_enter_i);
      repeat (10) @(negedge clk);
      chk(lg_n == 1 && lg_cmd[0] == 4, "R8 single sleep entry", lg_n, 1);
      chk(cke_o == 0 && cs_n_o == 1, "R8 held deselected with cke low",
          {cke_o, cs_n_o}, 1);
      chk(ready_o == 0, "R8 ready low in sleep", ready_o, 0);
      lg_n = 0;
      pulse(dpd_enter_i);
      pulse(start_i);
      repeat (10) @(negedge clk);
      chk(lg_n == 0 && cke_o == 0, "R9 strobes ignored in sleep", lg_n, 0);
   endtask

   task automatic t_wake(input int mw, input int ds, input int ps, input string tag);
      int t0;
      mode_word_i = ADDR_W'(mw); drive_sel_i = 2'(ds); pasr_sel_i = 3'(ps);
      lg_n = 0;
      @(negedge clk); dpd_exit_i = 1'b1; t0 = cyc;
      @(negedge clk); dpd_exit_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(cke_o == 1 && ready_o == 0, {tag, " R10 cke raised, not ready"},
          {cke_o, ready_o}, 2);
      check_bringup({tag, " R10"}, t0, mw, ds, ps);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset_state();
      t_ignore_before_start();
      t_first_bringup();
      t_ignore_while_ready();
      t_enter_sleep();
      t_wake(12'h023, 2, 6, "wake1");
      t_enter_sleep();
      t_wake(12'h231, 0, 5, "wake2");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule